// File: doc/BRIEF.md
# Link Event Interrupt Combiner

This block merges seven link-status event sources of a 10/100 Ethernet PHY management unit into one active-low interrupt line. Each status input is registered once. A qualifying edge on an input sets a sticky per-source flag. Six sources trigger on a rising edge. The link source triggers on a falling edge, so it reports the link going down. A flag drives the interrupt only when its enable bit is set and the combining mode control is on.

Software clears a flag by writing one to it. Such a write does not clear the flag directly. It asks the block to check the source's registered level. The flag clears only if the source has returned to its idle level: low for the rising-edge sources, high for the link source. Otherwise the flag and the interrupt stay set.

A small register port selects either the enable register or the flag register. It supports single-cycle writes and combinational reads. Bit 0 of both registers is not used.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable register reads 0x00. The flag register reads 0x80, because the energy-detect flag at bit 7 starts set. irq_n is high.
- R2: Bit 0 of both registers always reads 0, and a write to bit 0 has no effect. Bits 7..1 of the enable register read back exactly as written.
- R3: A rising edge on status bit 7 (energy detect), 6 (negotiation done), 5 (remote fault), 3 (partner acknowledge), 2 (parallel-detect fault) or 1 (page received) sets the flag of that bit. The flag register shows the new flag one clock edge after the input changed.
- R4: A falling edge on status bit 4 (link up) sets flag bit 4 one clock edge later. A rising edge on bit 4 sets no flag.
- R5: irq_n is low exactly when the mode input is 1 and at least one of bits 7..1 has both its flag and its enable bit set. While the mode input is 0, irq_n is high.
- R6: Writing 1 to a set flag clears it at the next edge when the source's registered level is idle. Idle is low for bits 7,6,5,3,2,1 and high for bit 4.
- R7: Writing 1 to a set flag leaves it set when the source's registered level is not idle. irq_n then stays low if that source is enabled.
- R8: Writing 0 to a flag bit has no effect, and no flag ever clears except through R6.
- R9: A write to the enable register takes effect at the next clock edge. Clearing an enable bit releases irq_n for that source while its flag stays set.
- R10: When a qualifying edge and a write-one check on the same flag meet in one cycle, the flag stays set.
- R11: The energy-detect level register resets to 1, so a present signal at reset release gives no new edge. After the input falls, a write of 1 to bit 7 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Enables the combined interrupt output |
| stat_i | input | 7 | Status levels, bits 7..1 (bit 4 = link up) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = flag register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong level-register or flag value shows up at the ports in two ways. It changes the flag register read one edge after the input edge. It also moves irq_n in the same cycle as the register changes. A wrong idle check shows only when a write-one is attempted. The bench therefore reads the flags back right after every clear attempt, in both the idle and the non-idle level. It also drives an edge together with a clear in one cycle, so a flag dropped there appears one edge later.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int REG_W      = 8;
    localparam int SRC_LO     = 1;
    localparam int SRC_HI     = 7;
    localparam int LINK_BIT   = 4;
    localparam int ENERGY_BIT = 7;

    typedef logic [REG_W-1:0] reg_t;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_FLAG   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        reg_t set;   // qualifying edge seen this cycle
        reg_t idle;  // registered level is at its idle value
    } evt_t;

    function automatic reg_t valid_bits();
        reg_t v;
        for (int i = 0; i < REG_W; i++) v[i] = (i >= SRC_LO) && (i <= SRC_HI);
        return v;
    endfunction

    function automatic reg_t onehot(input int idx);
        reg_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det
    import phy_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  reg_t stat,
    output evt_t evt
);
    localparam reg_t VALID    = valid_bits();
    localparam reg_t FALL_SEL = onehot(LINK_BIT);
    localparam reg_t SHAD_RST = onehot(ENERGY_BIT);

    reg_t shad;

    always_ff @(posedge clk) begin
        if (rst) shad <= SHAD_RST;
        else     shad <= stat & VALID;
    end

    reg_t rise, fall;
    always_comb begin
        rise     = stat & ~shad;
        fall     = ~stat & shad;
        evt.set  = ((rise & ~FALL_SEL) | (fall & FALL_SEL)) & VALID;
        evt.idle = ((~shad & ~FALL_SEL) | (shad & FALL_SEL)) & VALID;
    end

    AST_SHADOW_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (shad == ($past(stat) & VALID)))
        else $error("level register lost input");   // R3
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import phy_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    input  reg_t w1,
    output reg_t flag
);
    localparam reg_t RST_VAL = onehot(ENERGY_BIT);

    generate
        for (genvar i = 0; i < REG_W; i++) begin : g_bit
            if ((i >= SRC_LO) && (i <= SRC_HI)) begin : g_src
                always_ff @(posedge clk) begin
                    if (rst)             flag[i] <= RST_VAL[i];
                    else if (evt.set[i]) flag[i] <= 1'b1;
                    else if (w1[i] && evt.idle[i]) flag[i] <= 1'b0;
                end
            end else begin : g_none
                assign flag[i] = 1'b0;
            end
        end
    endgenerate

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flag & $past(evt.set)) == $past(evt.set)))
        else $error("edge not latched");   // R3
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flag & ~$past(flag) & ~$past(evt.set)) == '0))
        else $error("flag set without edge");   // R8
    AST_CLEAR_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((~flag & $past(flag) & ~($past(w1) & $past(evt.idle))) == '0))
        else $error("flag cleared illegally");   // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flag & $past(w1 & ~evt.idle & flag)) == $past(w1 & ~evt.idle & flag)))
        else $error("non-idle flag cleared");   // R7
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import phy_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  reg_t wdata,
    output reg_t mask
);
    localparam reg_t VALID = valid_bits();

    always_ff @(posedge clk) begin
        if (rst)     mask <= '0;
        else if (wr) mask <= wdata & VALID;
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(mask))
        else $error("enable register drifted");   // R9
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
    import phy_irq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_en,
    input  logic [SRC_HI:SRC_LO]   stat_i,
    input  logic                   reg_wr,
    input  logic                   reg_sel,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    output logic                   irq_n
);
    localparam reg_t VALID = valid_bits();

    reg_sel_e sel;
    reg_t     stat_v, w1_vec, flag, mask;
    evt_t     evt;
    logic     mask_wr;

    always_comb begin
        sel     = reg_sel_e'(reg_sel);
        stat_v  = '0;
        stat_v[SRC_HI:SRC_LO] = stat_i;
        mask_wr = reg_wr && (sel == SEL_ENABLE);
        w1_vec  = (reg_wr && (sel == SEL_FLAG)) ? (reg_wdata & VALID) : '0;
    end

    irq_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .stat (stat_v),
        .evt  (evt)
    );

    irq_flag_bank u_flags (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .w1   (w1_vec),
        .flag (flag)
    );

    irq_mask_reg u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr    (mask_wr),
        .wdata (reg_wdata),
        .mask  (mask)
    );

    always_comb begin
        reg_rdata = (sel == SEL_FLAG) ? flag : mask;
        irq_n     = ~(mode_en && |(flag & mask & VALID));
    end

    AST_BIT0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[0] == 1'b0)
        else $error("bit 0 nonzero");   // R2
    AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !mode_en |-> irq_n)
        else $error("irq while mode off");   // R5
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) && rst |-> (flag == onehot(ENERGY_BIT)) && (mask == '0))
        else $error("reset state wrong");   // R1
endmodule

// File: tb/phy_irq_ctrl_bench.sv
module phy_irq_ctrl_bench;
    localparam int ENERGY_DROP_CYC = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_en = 1'b0;
    logic [7:1] stat_i = 7'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    phy_irq_ctrl u_phy_irq_ctrl (
        .clk(clk), .rst(rst), .mode_en(mode_en), .stat_i(stat_i),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exq[$];
    event go;

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(go);
            while (exq.size() > 0) begin
                exp_t e;
                e = exq.pop_front();
                n_chk++;
                if (reg_rdata !== e.data || irq_n !== e.irq) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h irq_n=%b expected rdata=%h irq_n=%b",
                             e.tag, reg_rdata, irq_n, e.data, e.irq);
                end
            end
        end
    end

    task automatic expect_out(input logic sel, input logic [7:0] d,
                              input logic irq, input string tag);
        exp_t e;
        reg_sel = sel;
        #2;
        e.data = d; e.irq = irq; e.tag = tag;
        exq.push_back(e);
        ->go;
        #1;
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        stat_i = 7'b1001000;   // energy present (bit 7), link up (bit 4)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        expect_out(0, 8'h00, 1, "R1 enable after reset");
        expect_out(1, 8'h80, 1, "R1/R11 flags after reset");

        mode_en = 1'b1;
        write_reg(0, 8'hFF);
        expect_out(0, 8'hFE, 0, "R2 enable bit0 dropped / R5 irq low");
        // energy still present: write-one must not clear
        write_reg(1, 8'h81);
        expect_out(1, 8'h80, 0, "R7 busy energy flag stays");

        repeat (ENERGY_DROP_CYC) step();
        stat_i[7] = 1'b0;
        step(); step();
        expect_out(1, 8'h80, 0, "R8 falling energy sets nothing/clears nothing");
        write_reg(1, 8'h80);
        expect_out(1, 8'h00, 1, "R6/R11 energy flag cleared when idle");

        // rising edge on negotiation done
        stat_i[6] = 1'b1;
        step();
        expect_out(1, 8'h40, 0, "R3 rising bit6 sets flag");
        // link down
        stat_i[4] = 1'b0;
        step();
        expect_out(1, 8'h50, 0, "R4 falling link sets bit4");
        write_reg(1, 8'h10);
        expect_out(1, 8'h50, 0, "R7 link still down, bit4 stays");
        stat_i[4] = 1'b1;
        step();
        expect_out(1, 8'h50, 0, "R4 rising link sets nothing");
        write_reg(1, 8'h10);
        expect_out(1, 8'h40, 0, "R6 link idle high clears bit4");

        write_reg(1, 8'h00);
        expect_out(1, 8'h40, 0, "R8 write zero no effect");

        // enable clear takes effect at next edge
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 0; reg_wdata = 8'h00;
        expect_out(0, 8'hFE, 0, "R9 before edge irq still low");
        @(negedge clk);
        reg_wr = 1'b0;
        expect_out(0, 8'h00, 1, "R9 enable cleared irq high");
        expect_out(1, 8'h40, 1, "R9 flag kept");

        write_reg(0, 8'hFE);
        expect_out(0, 8'hFE, 0, "R5 enabled again irq low");
        mode_en = 1'b0;
        expect_out(1, 8'h40, 1, "R5 mode off irq high");
        mode_en = 1'b1;
        expect_out(1, 8'h40, 0, "R5 mode on irq low");

        // edge and write-one in the same cycle
        stat_i[6] = 1'b0;
        step();
        @(negedge clk);
        stat_i[6] = 1'b1;
        reg_wr = 1'b1; reg_sel = 1; reg_wdata = 8'h40;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
        expect_out(1, 8'h40, 0, "R10 edge beats clear");

        // several rising sources at once
        stat_i[5] = 1'b1; stat_i[3] = 1'b1; stat_i[2] = 1'b1; stat_i[1] = 1'b1;
        step();
        expect_out(1, 8'h6E, 0, "R3 bits 5,3,2,1 set together");
        write_reg(1, 8'h0C);
        expect_out(1, 8'h6E, 0, "R7 busy sources stay");
        stat_i[6:1] = 6'b001000;  // drop all but link
        step();
        write_reg(1, 8'hFF);
        expect_out(1, 8'h00, 1, "R6 all idle flags cleared, R2 bit0 zero");
        write_reg(0, 8'h01);
        expect_out(0, 8'h00, 1, "R2 enable bit0 ignored");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule